// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable behavioural model of a 32-bit pipelined synchronous SRAM. Its shared data bus is split into an input word, an output word and an output-drive flag. Every control and address input is sampled on the rising clock edge. A read passes through an array read register and then an output register. An access can be opened by either of two strobes. The processor strobe opens an access whose write, if any, is decided one edge later. The controller strobe opens an access that reads or writes at once. Three chip selects with mixed polarity qualify each strobe.

After an access has opened, the step input moves a two-bit burst counter through a four-word group, in either linear or interleaved order. While no strobe is present, each active cycle repeats a read or a write at the counter's address. Writes are byte-masked: a global write input overrides a byte-write enable that is qualified per lane. The output drive is cut on a write, on a deselecting edge, and in the first cycle after the block comes out of deselection. Outside those cases the active-low output-enable input controls the drive combinationally.

Top module: `bsram_top`

## Requirements
- R1: The word read at an address sampled on clock edge k appears on `dq_out` after edge k+1. If `outen_n` is low, `dq_drive` is 1 during that cycle.
- R2: An access opens only when `sel_a_n` is 0, `sel_b` is 1 and `sel_c_n` is 0 together with a strobe. When a strobe is sampled low with any select inactive, the block is deselected. `cpu_stb_n` is ignored whenever `sel_a_n` is 1, and a running access then continues unchanged.
- R3: A write opened by `cpu_stb_n` takes two edges. At the opening edge the write inputs are ignored and the access starts as a read. The write inputs sampled at the next edge, with no strobe present, write the captured address.
- R4: A write opened by `ctl_stb_n` (with `cpu_stb_n` high) writes `dq_in` at the sampled address on that same edge.
- R5: With `wr_all_n` = 0, all four byte lanes are written, whatever `wr_byte_n` and `lane_sel_n` hold.
- R6: With `wr_all_n` = 1 and `wr_byte_n` = 0, only lane i (bits 8i+7..8i) with `lane_sel_n[i]` = 0 is written, and the other lanes keep their contents. With both `wr_all_n` and `wr_byte_n` high, the cycle is a read and no lane changes.
- R7: In the cycle after an access opens from the deselected state, `dq_drive` is 0 even with `outen_n` low.
- R8: In the cycle after any write edge, `dq_drive` is 0 regardless of `outen_n`.
- R9: After reset, and after a deselecting edge, `dq_drive` is 0.
- R10: Reads opened on consecutive edges each deliver their own word on consecutive cycles.
- R11: `dq_drive` follows `outen_n` combinationally: it is 0 in any cycle where `outen_n` is 1.
- R12: With no strobe and `step_n` = 0, the burst address advances. With `order_linear` = 1, the low two bits follow start+1, +2, +3 modulo 4, and the upper address bits stay fixed.
- R13: With `order_linear` = 0, the low two bits of the burst address are the start's low bits XOR the burst count 1, 2, 3.
- R14: With no strobe and `step_n` = 1 during an active access, the access is repeated at the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address sampled with a strobe |
| cpu_stb_n | input | 1 | Processor access strobe, active low |
| ctl_stb_n | input | 1 | Controller access strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Chip select A, active low, also gates the processor strobe |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| outen_n | input | 1 | Output enable, active low, combinational |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte write enable, active low |
| lane_sel_n | input | DATA_W/8 | Per-lane write selects, active low |
| order_linear | input | 1 | 1 selects linear burst order, 0 selects interleaved |
| dq_in | input | DATA_W | Write data |
| dq_out | output | DATA_W | Output register contents |
| dq_drive | output | 1 | 1 when the output bus would be driven |

## Verification
The case that is hardest to reach from the ports is a processor-strobe write. Its opening edge must be seen to discard write inputs that would corrupt memory if they were honoured. The stimulus therefore opens that access with the global write asserted and all-ones data. It then applies a single-lane byte write at the second edge, and finally reads the word back. The read-back must show the old upper lanes beside the new low lane. A second hard case is a processor strobe that arrives while `sel_a_n` is high in the middle of a running repeated read. The bench checks that the old word keeps streaming rather than a new address or a deselect.

// File: rtl/bsram_pkg.sv
// Shared constants and types for the burst SRAM model.
// Assumes byte lanes of 8 bits and a four-word burst group.
package bsram_pkg;
    localparam int LANE_W  = 8;
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/bsram_burst_ctr.sv
// Burst address generator: captures a start address and steps a
// two-bit counter through the four-word group in linear or
// interleaved order. Assumes ld and step are never high together.
module bsram_burst_ctr
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic              step,
    input  logic              lin,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] nxt_addr
);
    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] cnt_nx;

    // Maps a start offset and burst count to a word offset
    function automatic logic [BURST_W-1:0] burst_low(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] cnt,
        input logic               linear
    );
        return linear ? (start + cnt) : (start ^ cnt);
    endfunction

    // Current and following burst addresses
    always_comb begin
        cnt_nx   = cnt_q + 1'b1;
        cur_addr = {base_q[ADDR_W-1:BURST_W], burst_low(base_q[BURST_W-1:0], cnt_q, lin)};
        nxt_addr = {base_q[ADDR_W-1:BURST_W], burst_low(base_q[BURST_W-1:0], cnt_nx, lin)};
    end

    // Start-address capture and counter stepping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (ld) begin
            base_q <= addr_in;
            cnt_q  <= '0;
        end else if (step) begin
            cnt_q  <= cnt_nx;
        end
    end

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cur_addr == $past(addr_in))); // R1

    AST_BURST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld) |=> $stable(cur_addr[ADDR_W-1:BURST_W])); // R12
endmodule

// File: rtl/bsram_array.sv
// Byte-lane storage with a registered read port. One lane memory
// per byte; assumes a read and a write never share an edge.
module bsram_array
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4
) (
    input  logic                    clk,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    wr_en,
    input  logic [BYTES-1:0]        wr_mask,
    input  logic [BYTES*LANE_W-1:0] wdata,
    input  logic                    rd_en,
    output logic [BYTES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];
        logic [LANE_W-1:0] lane_rd;

        // Masked write and registered read of one byte lane
        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[g]) begin
                lane_mem[addr] <= wdata[g*LANE_W +: LANE_W];
            end
            if (rd_en) begin
                lane_rd <= lane_mem[addr];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = lane_rd;
    end
endmodule

// File: rtl/bsram_ctrl.sv
// Access decoder: qualifies the two strobes with the chip selects,
// tracks selection and the pending processor-strobe write, and
// issues one read, write or no-op per edge with its address.
// Assumes the burst counter supplies current and next addresses.
module bsram_ctrl
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_stb_n,
    input  logic              ctl_stb_n,
    input  logic              step_n,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              wr_all_n,
    input  logic              wr_byte_n,
    input  logic [BYTES-1:0]  lane_sel_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] nxt_addr,
    output logic              ld,
    output logic              step,
    output logic [ADDR_W-1:0] op_addr,
    output logic              wr_en,
    output logic [BYTES-1:0]  wr_mask,
    output logic              rd_en,
    output logic              rd_pend,
    output logic              kill
);
    logic             cs_ok, cpu_req, ctl_req, start, desel, wr_req;
    logic [BYTES-1:0] mask_req;
    logic             active_q, cpu_pend_q, rd_pend_q;
    op_e              op;

    // Strobe qualification and write-mask decode
    always_comb begin
        cs_ok    = !sel_a_n && sel_b && !sel_c_n;
        cpu_req  = !cpu_stb_n && !sel_a_n;
        ctl_req  = !ctl_stb_n && !cpu_req;
        start    = cpu_req || ctl_req;
        desel    = start && !cs_ok;
        mask_req = !wr_all_n ? '1 : (!wr_byte_n ? ~lane_sel_n : '0);
        wr_req   = |mask_req;
    end

    // Per-edge operation choice with strobe priority
    always_comb begin
        op      = OP_NONE;
        ld      = 1'b0;
        step    = 1'b0;
        op_addr = cur_addr;
        if (desel) begin
            op = OP_NONE;
        end else if (cpu_req) begin
            ld      = 1'b1;
            op_addr = addr_in;
            op      = OP_READ;
        end else if (ctl_req) begin
            ld      = 1'b1;
            op_addr = addr_in;
            op      = wr_req ? OP_WRITE : OP_READ;
        end else if (active_q) begin
            if (cpu_pend_q && wr_req) begin
                op = OP_WRITE;
            end else begin
                step    = !step_n;
                op_addr = step ? nxt_addr : cur_addr;
                op      = wr_req ? OP_WRITE : OP_READ;
            end
        end
        wr_en   = (op == OP_WRITE);
        wr_mask = wr_en ? mask_req : '0;
        rd_en   = (op == OP_READ);
        kill    = desel || wr_en;
        rd_pend = rd_pend_q;
    end

    // Selection, pending-write and read-pipeline state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q   <= 1'b0;
            cpu_pend_q <= 1'b0;
            rd_pend_q  <= 1'b0;
        end else begin
            rd_pend_q  <= rd_en;
            cpu_pend_q <= cpu_req && cs_ok;
            if (desel) begin
                active_q <= 1'b0;
            end else if (start) begin
                active_q <= 1'b1;
            end
        end
    end

    AST_CPU_STB_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_stb_n && sel_a_n && ctl_stb_n) |-> !ld); // R2

    AST_DESEL_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_stb_n && cpu_stb_n && (sel_a_n || !sel_b || sel_c_n)) |-> (!wr_en && !rd_en)); // R9

    AST_CPU_FIRST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_stb_n && !sel_a_n && sel_b && !sel_c_n) |-> !wr_en); // R3

    AST_CPU_SECOND_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_stb_n && !sel_a_n && sel_b && !sel_c_n)
        |=> (!(cpu_stb_n && ctl_stb_n && !wr_all_n) || (wr_en && op_addr == $past(addr_in)))); // R3

    AST_CTL_WRITE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_stb_n && cpu_stb_n && !sel_a_n && sel_b && !sel_c_n && !wr_all_n)
        |-> (wr_en && op_addr == addr_in)); // R4
endmodule

// File: rtl/bsram_out.sv
// Output stage: output register plus drive qualification. Drive is
// dropped after write or deselect edges and gated by output enable.
// Assumes rd_pend marks that rd_data holds a fresh array read.
module bsram_out #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_pend,
    input  logic              kill,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              outen_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_drive
);
    logic              valid_q;
    logic [DATA_W-1:0] data_q;

    // Output register load and validity tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= rd_pend && !kill;
            if (rd_pend) begin
                data_q <= rd_data;
            end
        end
    end

    // Combinational output-enable gating
    always_comb begin
        dq_out   = data_q;
        dq_drive = valid_q && !outen_n;
    end

    AST_WRITE_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !dq_drive); // R8

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pend && !kill) |=> (dq_drive == !outen_n)); // R1
endmodule

// File: rtl/bsram_top.sv
// Pipelined burst synchronous SRAM: wires the access decoder, burst
// counter, byte-lane array and output stage. Depth is 2**ADDR_W words;
// assumes ADDR_W > 2 and DATA_W a multiple of 8.
module bsram_top
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cpu_stb_n,
    input  logic              ctl_stb_n,
    input  logic              step_n,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              outen_n,
    input  logic              wr_all_n,
    input  logic              wr_byte_n,
    input  logic [DATA_W/8-1:0] lane_sel_n,
    input  logic              order_linear,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_drive
);
    localparam int BYTES = DATA_W / LANE_W;

    logic              ld, step, wr_en, rd_en, rd_pend, kill;
    logic [ADDR_W-1:0] cur_addr, nxt_addr, op_addr;
    logic [BYTES-1:0]  wr_mask;
    logic [DATA_W-1:0] rd_data;

    bsram_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .step_n(step_n),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n),
        .addr_in(addr), .cur_addr(cur_addr), .nxt_addr(nxt_addr),
        .ld(ld), .step(step), .op_addr(op_addr),
        .wr_en(wr_en), .wr_mask(wr_mask), .rd_en(rd_en),
        .rd_pend(rd_pend), .kill(kill)
    );

    bsram_burst_ctr #(.ADDR_W(ADDR_W)) u_burst (
        .clk(clk), .rst_n(rst_n), .ld(ld), .step(step), .lin(order_linear),
        .addr_in(addr), .cur_addr(cur_addr), .nxt_addr(nxt_addr)
    );

    bsram_array #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_array (
        .clk(clk), .addr(op_addr), .wr_en(wr_en), .wr_mask(wr_mask),
        .wdata(dq_in), .rd_en(rd_en), .rdata(rd_data)
    );

    bsram_out #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .rd_pend(rd_pend), .kill(kill),
        .rd_data(rd_data), .outen_n(outen_n),
        .dq_out(dq_out), .dq_drive(dq_drive)
    );
endmodule

// File: tb/bsram_top_tb.sv
`timescale 1ns/1ps
module bsram_top_tb;
    localparam int AW = 6;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          cpu_stb_n = 1'b1, ctl_stb_n = 1'b1, step_n = 1'b1;
    logic          sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
    logic          outen_n = 1'b0, wr_all_n = 1'b1, wr_byte_n = 1'b1;
    logic [3:0]    lane_sel_n = 4'hF;
    logic          order_linear = 1'b1;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_drive;

    always #2 clk = ~clk;

    bsram_top #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .step_n(step_n),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .outen_n(outen_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
        .lane_sel_n(lane_sel_n), .order_linear(order_linear),
        .dq_in(dq_in), .dq_out(dq_out), .dq_drive(dq_drive)
    );

    typedef struct {
        bit          chk;
        bit          en;
        logic [31:0] d;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          total = 0;
    int          bad = 0;
    bit          done = 0;
    logic [31:0] ref_mem [0:63];

    // Monitor: pops one expectation per edge and compares after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                if (it.chk) begin
                    total++;
                    if (dq_drive !== it.en || (it.en && dq_out !== it.d)) begin
                        bad++;
                        $display("FAIL %s: drive=%b data=%h expected drive=%b data=%h",
                                 it.tag, dq_drive, dq_out, it.en, it.d);
                    end
                end
            end
        end
    end

    // Driver primitive: inputs already set; push expectation, wait one cycle
    task automatic cyc(input bit en, input logic [31:0] d, input bit chk, input string tag);
        exp_t it;
        it.chk = chk; it.en = en; it.d = d; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic set_def();
        cpu_stb_n = 1'b1; ctl_stb_n = 1'b1; step_n = 1'b1;
        sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
        outen_n = 1'b0; wr_all_n = 1'b1; wr_byte_n = 1'b1;
        lane_sel_n = 4'hF; dq_in = '0; addr = '0;
    endtask

    // Reference byte-mask update taken from R5 and R6
    task automatic ref_write(input int a, input logic [31:0] d, input bit g_n,
                             input bit b_n, input logic [3:0] s_n);
        for (int i = 0; i < 4; i++) begin
            if (!g_n || (!b_n && !s_n[i])) ref_mem[a][i*8 +: 8] = d[i*8 +: 8];
        end
    endtask

    task automatic t_ctl_wr(input int a, input logic [31:0] d, input bit g_n,
                            input bit b_n, input logic [3:0] s_n, input string tag);
        set_def();
        ctl_stb_n = 1'b0; addr = AW'(a); dq_in = d;
        wr_all_n = g_n; wr_byte_n = b_n; lane_sel_n = s_n;
        ref_write(a, d, g_n, b_n, s_n);
        cyc(1'b0, '0, 1'b1, tag);
    endtask

    task automatic t_desel();
        set_def();
        ctl_stb_n = 1'b0; sel_b = 1'b0;
        cyc(1'b0, '0, 1'b1, "R9 deselect");
    endtask

    task automatic t_ctl_rd(input int a, input bit en, input logic [31:0] d, input string tag);
        set_def();
        ctl_stb_n = 1'b0; addr = AW'(a);
        cyc(en, d, 1'b1, tag);
    endtask

    task automatic t_idle(input bit stp_n, input bit en, input logic [31:0] d, input string tag);
        set_def();
        step_n = stp_n;
        cyc(en, d, 1'b1, tag);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R9: reset state
        for (int i = 0; i < 3; i++) cyc(1'b0, '0, 1'b1, "R9 reset");
        rst_n = 1'b1;

        // R4/R8: controller-strobe global writes, drive low after each
        for (int a = 8; a < 12; a++) t_ctl_wr(a, 32'hA500_0000 + a * 32'h0001_0101, 1'b0, 1'b1, 4'hF, "R4/R8");
        for (int a = 16; a < 20; a++) t_ctl_wr(a, 32'h5A00_0000 + a * 32'h0001_0203, 1'b0, 1'b1, 4'hF, "R4/R8");
        t_desel();

        // R7 first cycle tri-state, R1 latency, R14 repeat
        t_ctl_rd(8, 1'b0, '0, "R7");
        t_idle(1'b1, 1'b1, ref_mem[8], "R1/R4");
        t_idle(1'b1, 1'b1, ref_mem[8], "R14");
        t_desel();

        // R10 back-to-back reads, R11 output enable
        t_ctl_rd(9, 1'b0, '0, "R7");
        t_ctl_rd(10, 1'b1, ref_mem[9], "R10");
        t_ctl_rd(11, 1'b1, ref_mem[10], "R10");
        set_def(); outen_n = 1'b1; cyc(1'b0, '0, 1'b1, "R11");
        t_idle(1'b1, 1'b1, ref_mem[11], "R11");

        // R2: processor strobe ignored with sel_a_n high, access continues
        set_def(); cpu_stb_n = 1'b0; sel_a_n = 1'b1; addr = AW'(8);
        cyc(1'b1, ref_mem[11], 1'b1, "R2");
        t_idle(1'b1, 1'b1, ref_mem[11], "R2");
        // R2: wrong polarity on sel_c_n deselects
        set_def(); ctl_stb_n = 1'b0; sel_c_n = 1'b1; addr = AW'(9);
        cyc(1'b0, '0, 1'b1, "R2");
        t_idle(1'b1, 1'b0, '0, "R2");

        // R6: byte write on lanes 1 and 3, then no-write cycle
        t_ctl_wr(9, 32'h1122_3344, 1'b1, 1'b0, 4'b0101, "R6/R8");
        set_def(); ctl_stb_n = 1'b0; addr = AW'(10); lane_sel_n = 4'h0; dq_in = 32'hFFFF_FFFF;
        cyc(1'b0, '0, 1'b1, "R6");
        t_ctl_rd(9, 1'b1, ref_mem[10], "R6");
        t_idle(1'b1, 1'b1, ref_mem[9], "R6");
        t_desel();

        // R5: global write overrides byte controls
        t_ctl_wr(10, 32'hDEAD_BEEF, 1'b0, 1'b0, 4'hF, "R5/R8");
        t_ctl_rd(10, 1'b0, '0, "R8");
        t_idle(1'b1, 1'b1, ref_mem[10], "R5");
        t_desel();

        // R3: processor-strobe write, hostile first-edge qualifiers
        set_def(); cpu_stb_n = 1'b0; addr = AW'(11); wr_all_n = 1'b0; dq_in = 32'hFFFF_FFFF;
        cyc(1'b0, '0, 1'b1, "R3/R7");
        set_def(); wr_byte_n = 1'b0; lane_sel_n = 4'b1110; dq_in = 32'h0000_00C3;
        ref_write(11, 32'h0000_00C3, 1'b1, 1'b0, 4'b1110);
        cyc(1'b0, '0, 1'b1, "R3/R8");
        t_ctl_rd(11, 1'b0, '0, "R8");
        t_idle(1'b1, 1'b1, ref_mem[11], "R3");
        t_desel();

        // R3: processor-strobe read
        set_def(); cpu_stb_n = 1'b0; addr = AW'(8);
        cyc(1'b0, '0, 1'b1, "R3/R7");
        t_idle(1'b1, 1'b1, ref_mem[8], "R3");
        t_desel();

        // R12: linear burst from offset 2
        order_linear = 1'b1;
        t_ctl_rd(18, 1'b0, '0, "R7");
        t_idle(1'b0, 1'b1, ref_mem[18], "R12");
        t_idle(1'b0, 1'b1, ref_mem[19], "R12");
        t_idle(1'b0, 1'b1, ref_mem[16], "R12");
        t_idle(1'b1, 1'b1, ref_mem[17], "R12");
        t_desel();

        // R13: interleaved burst from offset 1
        order_linear = 1'b0;
        t_ctl_rd(17, 1'b0, '0, "R7");
        t_idle(1'b0, 1'b1, ref_mem[17], "R13");
        t_idle(1'b0, 1'b1, ref_mem[16], "R13");
        t_idle(1'b0, 1'b1, ref_mem[19], "R13");
        t_idle(1'b1, 1'b1, ref_mem[18], "R13");
        t_desel();

        set_def();
        for (int i = 0; i < 3; i++) cyc(1'b0, '0, 1'b0, "drain");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule